// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block sits between a word-wide request port and an asynchronous DRAM whose cells form a square array of 2048 rows by 2048 columns. A request carries a 22-bit word address. The upper 11 bits select the row and the lower 11 bits select the column. Both halves reach the device over the same 11 address pins. The row is latched by a falling row strobe and the column by a falling column strobe. All analog timing limits are given as parameters counted in clock cycles. The defaults are the nanosecond limits rounded up at a 5 ns clock.

After an access the row stays open. A later request to the same row needs only a column strobe. A request to another row first precharges and then re-opens the row, and it still respects the minimum spacing between row activations. A refresh scheduler walks through every row at an even interval, so that each row is refreshed well inside the retention time. A refresh takes precedence over new requests once the access in progress has finished. Each refresh is an activation without a column strobe. Read data comes back on a one-cycle response pulse, in request order.

Top module: `dram_page_ctl`

## Requirements
- R1: At a falling RAS the address pins carry the row (request bits 21:11) and stay unchanged through the following cycle. At a falling CAS they carry the column (request bits 10:0), so each word lands at its own cell.
- R2: Two falling edges of RAS are at least T_RC cycles apart.
- R3: RAS stays high for at least T_RP = T_RC - T_RAC cycles before it falls again.
- R4: Read data is captured no earlier than T_RAC cycles after RAS fell and T_CAC cycles after CAS fell. It equals the last word written to that address, or the device's initial contents.
- R5: Falling edges of CAS within one open row are at least T_PC cycles apart. A stream of requests to the open row gets CAS edges exactly T_PC apart.
- R6: A request to the open row produces no RAS edge, and CAS only ever falls while RAS is low. After an idle spell, such a read responds T_CAC+2 cycles after the cycle in which it was offered and accepted.
- R7: A read while no row is open and the row cycle has elapsed responds T_RAC+2 cycles after acceptance.
- R8: A request to a row other than the open one raises RAS, precharges, and activates the new row once.
- R9: A refresh is a RAS activation with no CAS. Refresh rows follow 0, 1, 2, … modulo 2048, and successive refreshes are REF_INTERVAL cycles apart give or take the service delay.
- R10: During reset RAS, CAS and WE are high, the data driver is off and no response is signalled. After reset, req_ready is high.
- R11: At a falling CAS for a write, WE is low and the data driver is on. For a read, WE is high and the driver is off.
- R12: Exactly one response is returned per accepted read, in acceptance order, and none for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in the upper half, column in the lower half |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven to the device |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 16 | Data returned by the device |

## Verification
The hardest situation to reach from the ports is a refresh that falls due while a row-miss sequence is half done. In that case the precharge, the row-cycle wait and the refresh activation all compete in one window. Random traffic mixes a handful of hot rows with rare far rows, and it keeps running across several refresh intervals, so refresh ticks land at arbitrary points of open, precharging and activating rows. The device model in the bench returns a poison word whenever a read is captured before both access times have elapsed. Any early sample therefore shows up as a data miscompare, beside direct checks of the strobe spacing.

// File: rtl/dram_pc_pkg.sv
package dram_pc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // no row open
    ST_ACT,    // waiting to activate a row
    ST_RAS,    // row strobe just fell
    ST_OPEN,   // row open, column work may start
    ST_CAS     // column strobe low
  } seq_state_e;
endpackage

// File: rtl/dram_since_ctr.sv
module dram_since_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] since
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  logic [W-1:0] since_d;

  always_comb begin
    if (restart)          since_d = W'(1);
    else if (since == SAT) since_d = SAT;
    else                  since_d = since + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= SAT;
    else        since <= since_d;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 780,
  parameter int ROW_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0]    tcnt_q, tcnt_d;
  logic             tick;
  logic             pend_d;
  logic [ROW_W-1:0] row_d;

  assign tick = (tcnt_q == LAST);

  always_comb begin
    tcnt_d = tick ? '0 : tcnt_q + TW'(1);
    pend_d = tick | (pend & ~done);
    row_d  = done ? row + ROW_W'(1) : row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend   <= 1'b0;
      row    <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend   <= pend_d;
      if (done) row <= row_d;
    end
  end

  // R9: each refresh is served before the next one falls due
  a_r9_served_in_time: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !pend);
  // R9: completion only for an outstanding refresh
  a_r9_done_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend);
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pc_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int DW    = 16,
  parameter int CNT_W = 5,
  parameter int T_RAC = 12,
  parameter int T_RC  = 22,
  parameter int T_CAC = 3,
  parameter int T_PC  = 7,
  parameter int T_RP  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] addr,
  output logic [DW-1:0]            dq_out,
  output logic                     dq_oe,
  input  logic [DW-1:0]            dq_in,
  input  logic [CNT_W-1:0]         ras_since,
  input  logic [CNT_W-1:0]         cas_since,
  input  logic [CNT_W-1:0]         pre_since,
  output logic                     ras_go,
  output logic                     ras_up,
  output logic                     cas_go,
  input  logic                     ref_pend,
  input  logic [ROW_W-1:0]         ref_row,
  output logic                     ref_done
);
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int RCD = ((T_RAC - T_CAC) > 2) ? (T_RAC - T_CAC) : 2;
  localparam logic [CNT_W-1:0] K_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] K_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] K_RAC = CNT_W'(T_RAC);
  localparam logic [CNT_W-1:0] K_CAC = CNT_W'(T_CAC);
  localparam logic [CNT_W-1:0] K_PC  = CNT_W'(T_PC);
  localparam logic [CNT_W-1:0] K_RCD = CNT_W'(RCD);

  seq_state_e       state_q, state_d;
  logic             ras_n_d, cas_n_d, we_n_d, oe_d;
  logic [PIN_W-1:0] addr_d;
  logic [DW-1:0]    dout_d;
  logic [ROW_W-1:0] open_row_q, open_row_d;
  logic             job_we_q, job_we_d;
  logic [COL_W-1:0] job_col_q, job_col_d;
  logic [DW-1:0]    job_wd_q, job_wd_d;
  logic             job_ref_q, job_ref_d;
  logic             col_pend_q, col_pend_d;
  logic             rsp_valid_d;
  logic [DW-1:0]    rsp_rdata_d;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             hit, act_ok, close_ok;

  assign req_row  = req_addr[ADDR_W-1:COL_W];
  assign req_col  = req_addr[COL_W-1:0];
  assign hit      = (req_row == open_row_q);
  assign act_ok   = (ras_since >= K_RC) && (pre_since >= K_RP);
  assign close_ok = (ras_since >= K_RAC);

  always_comb begin
    state_d     = state_q;
    ras_n_d     = ras_n;
    cas_n_d     = cas_n;
    we_n_d      = we_n;
    oe_d        = dq_oe;
    addr_d      = addr;
    dout_d      = dq_out;
    open_row_d  = open_row_q;
    job_we_d    = job_we_q;
    job_col_d   = job_col_q;
    job_wd_d    = job_wd_q;
    job_ref_d   = job_ref_q;
    col_pend_d  = col_pend_q;
    rsp_valid_d = 1'b0;
    rsp_rdata_d = rsp_rdata;
    req_ready   = 1'b0;
    ras_go      = 1'b0;
    ras_up      = 1'b0;
    cas_go      = 1'b0;
    ref_done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = !ref_pend;
        if (ref_pend) begin
          addr_d    = PIN_W'(ref_row);
          job_ref_d = 1'b1;
          state_d   = ST_ACT;
        end else if (req_valid) begin
          addr_d     = PIN_W'(req_row);
          open_row_d = req_row;
          job_we_d   = req_we;
          job_col_d  = req_col;
          job_wd_d   = req_wdata;
          job_ref_d  = 1'b0;
          state_d    = ST_ACT;
        end
      end
      ST_ACT: begin
        if (act_ok) begin
          ras_n_d = 1'b0;
          ras_go  = 1'b1;
          state_d = ST_RAS;
        end
      end
      ST_RAS: begin
        if (job_ref_q) begin
          if (close_ok) begin
            ras_n_d  = 1'b1;
            ras_up   = 1'b1;
            ref_done = 1'b1;
            state_d  = ST_IDLE;
          end
        end else begin
          addr_d     = PIN_W'(job_col_q);
          we_n_d     = !job_we_q;
          oe_d       = job_we_q;
          dout_d     = job_wd_q;
          col_pend_d = 1'b1;
          state_d    = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (col_pend_q) begin
          if ((cas_since >= K_PC) && (ras_since >= K_RCD)) begin
            cas_n_d = 1'b0;
            cas_go  = 1'b1;
            state_d = ST_CAS;
          end
        end else if (ref_pend) begin
          if (close_ok) begin
            ras_n_d = 1'b1;
            ras_up  = 1'b1;
            state_d = ST_IDLE;
          end
        end else begin
          req_ready = hit || close_ok;
          if (req_valid && req_ready) begin
            job_we_d  = req_we;
            job_col_d = req_col;
            job_wd_d  = req_wdata;
            job_ref_d = 1'b0;
            if (hit) begin
              addr_d     = PIN_W'(req_col);
              we_n_d     = !req_we;
              oe_d       = req_we;
              dout_d     = req_wdata;
              col_pend_d = 1'b1;
            end else begin
              ras_n_d    = 1'b1;
              ras_up     = 1'b1;
              addr_d     = PIN_W'(req_row);
              open_row_d = req_row;
              state_d    = ST_ACT;
            end
          end
        end
      end
      ST_CAS: begin
        if (cas_since >= K_CAC) begin
          cas_n_d    = 1'b1;
          we_n_d     = 1'b1;
          oe_d       = 1'b0;
          col_pend_d = 1'b0;
          state_d    = ST_OPEN;
          if (we_n) begin
            rsp_valid_d = 1'b1;
            rsp_rdata_d = dq_in;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      we_n       <= 1'b1;
      dq_oe      <= 1'b0;
      addr       <= '0;
      dq_out     <= '0;
      open_row_q <= '0;
      job_we_q   <= 1'b0;
      job_col_q  <= '0;
      job_wd_q   <= '0;
      job_ref_q  <= 1'b0;
      col_pend_q <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      state_q    <= state_d;
      ras_n      <= ras_n_d;
      cas_n      <= cas_n_d;
      we_n       <= we_n_d;
      dq_oe      <= oe_d;
      addr       <= addr_d;
      dq_out     <= dout_d;
      open_row_q <= open_row_d;
      job_we_q   <= job_we_d;
      job_col_q  <= job_col_d;
      job_wd_q   <= job_wd_d;
      job_ref_q  <= job_ref_d;
      col_pend_q <= col_pend_d;
      rsp_valid  <= rsp_valid_d;
      if (rsp_valid_d) rsp_rdata <= rsp_rdata_d;
    end
  end

  // R1: the row address is held through the cycle after RAS falls
  a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ras_go |=> $stable(addr));
  // R2: row activations respect the row cycle
  a_r2_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ras_go |-> ras_since >= K_RC);
  // R3: precharge time before a new activation
  a_r3_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    ras_go |-> pre_since >= K_RP);
  // R4: capture only after both access times
  a_r4_capture_window: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(ras_since) >= K_RAC) && ($past(cas_since) >= K_CAC));
  // R5: page-mode column cycle
  a_r5_column_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cas_go |-> cas_since >= K_PC);
  // R6: column strobe only inside an open row
  a_r6_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R11: data driver only while writing
  a_r11_driver_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
endmodule

// File: rtl/dram_page_ctl.sv
module dram_page_ctl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 16,
  parameter int T_RAC        = 12,
  parameter int T_RC         = 22,
  parameter int T_CAC        = 3,
  parameter int T_PC         = 7,
  parameter int REF_INTERVAL = 780
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int T_RP  = T_RC - T_RAC;
  localparam int CNT_W = $clog2(T_RC + 2);

  logic             ras_go, ras_up, cas_go;
  logic             ref_pend, ref_done;
  logic [ROW_W-1:0] ref_row;
  logic [2:0]       restart_v;
  logic [CNT_W-1:0] since_v [3];

  // index 0: since RAS fell, 1: since CAS fell, 2: since RAS rose
  assign restart_v = {ras_up, cas_go, ras_go};

  for (genvar g = 0; g < 3; g++) begin : g_since
    dram_since_ctr #(.W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart_v[g]),
      .since   (since_v[g])
    );
  end

  dram_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (ref_done),
    .pend  (ref_pend),
    .row   (ref_row)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DATA_W), .CNT_W(CNT_W),
    .T_RAC(T_RAC), .T_RC(T_RC), .T_CAC(T_CAC), .T_PC(T_PC), .T_RP(T_RP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .addr      (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .dq_in     (dram_dq_in),
    .ras_since (since_v[0]),
    .cas_since (since_v[1]),
    .pre_since (since_v[2]),
    .ras_go    (ras_go),
    .ras_up    (ras_up),
    .cas_go    (cas_go),
    .ref_pend  (ref_pend),
    .ref_row   (ref_row),
    .ref_done  (ref_done)
  );
endmodule

// File: tb/tb_dram_page_ctl.sv
`timescale 1ns/1ps
module tb_dram_page_ctl;
  localparam int T_RAC = 12;
  localparam int T_RC  = 22;
  localparam int T_CAC = 3;
  localparam int T_PC  = 7;
  localparam int T_RP  = T_RC - T_RAC;
  localparam int REF   = 780;
  localparam int SLACK = 80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_we;
  logic [21:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [10:0] dram_addr;
  logic [15:0] dram_dq_out, dram_dq_in;

  dram_page_ctl #(.T_RAC(T_RAC), .T_RC(T_RC), .T_CAC(T_CAC), .T_PC(T_PC),
                  .REF_INTERVAL(REF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] seedval(input int a);
    return 16'(a * 7 + 13) ^ 16'hC3A5;
  endfunction

  // device model
  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];
  logic [10:0] dev_row, dev_col;
  bit prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0;
  int ras_age = 0, cas_age = 0;
  int last_fall = -1000, last_rise = -1000, last_cas = -1000, last_ref = -1;
  int ras_falls = 0, ref_seen = 0, exp_ref_row = 0, last_cas_gap = 0, key = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_ras_n && prev_ras) begin
        chk(cyc - last_fall >= T_RC, "R2", "RAS fall spacing", cyc - last_fall, T_RC);
        chk(cyc - last_rise >= T_RP, "R3", "RAS high time", cyc - last_rise, T_RP);
        last_fall = cyc;
        dev_row = dram_addr;
        cas_seen = 1'b0;
        ras_falls++;
      end
      if (dram_ras_n && !prev_ras) begin
        last_rise = cyc;
        if (!cas_seen) begin
          chk(int'(dev_row) == exp_ref_row, "R9", "refresh row", dev_row, exp_ref_row);
          if (last_ref >= 0)
            chk((last_fall - last_ref >= REF - SLACK) && (last_fall - last_ref <= REF + SLACK),
                "R9", "refresh spacing", last_fall - last_ref, REF);
          else
            chk(last_fall <= REF + SLACK, "R9", "first refresh time", last_fall, REF);
          last_ref = last_fall;
          exp_ref_row = (exp_ref_row + 1) % 2048;
          ref_seen++;
        end
      end
      if (!dram_cas_n && prev_cas) begin
        chk(!dram_ras_n, "R6", "CAS fell with RAS high", dram_ras_n, 0);
        if (cas_seen) begin
          last_cas_gap = cyc - last_cas;
          chk(last_cas_gap >= T_PC, "R5", "CAS spacing", last_cas_gap, T_PC);
        end
        cas_seen = 1'b1;
        last_cas = cyc;
        dev_col = dram_addr;
        chk(dram_dq_oe == !dram_we_n, "R11", "driver enable vs WE", dram_dq_oe, !dram_we_n);
        if (!dram_we_n) dev_mem[int'({dev_row, dev_col})] = dram_dq_out;
      end
    end
    ras_age = dram_ras_n ? 0 : ras_age + 1;
    cas_age = dram_cas_n ? 0 : cas_age + 1;
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
    key = int'({dev_row, dev_col});
    if (!dram_cas_n && dram_we_n && cas_age >= T_CAC && ras_age >= T_RAC)
      dram_dq_in = dev_mem.exists(key) ? dev_mem[key] : seedval(key);
    else
      dram_dq_in = 16'hDEAD;
  end

  // response monitor
  logic [15:0] exp_q [$];
  int hs_q [$];
  int last_lat = 0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R12", "response without read", 1, 0);
      else begin
        logic [15:0] e;
        int h;
        e = exp_q.pop_front();
        h = hs_q.pop_front();
        chk(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
        last_lat = cyc - h;
      end
    end
  end

  task automatic do_req(input bit we, input logic [10:0] row, input logic [10:0] col,
                        input logic [15:0] d);
    int waitc = 0;
    int a = int'({row, col});
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {row, col}; req_wdata = d;
    #1;
    while (!req_ready && waitc < 1000) begin
      @(negedge clk); #1; waitc++;
    end
    if (we) ref_mem[a] = d;
    else begin
      exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : seedval(a));
      hs_q.push_back(cyc);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R12", "watchdog expired at cycle", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int rf, rs, r, seed_ret;
    logic [10:0] rw, cl;
    seed_ret = int'($urandom(32'd1357));
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(dram_ras_n == 1'b1, "R10", "RAS in reset", dram_ras_n, 1);
    chk(dram_cas_n == 1'b1, "R10", "CAS in reset", dram_cas_n, 1);
    chk(dram_we_n == 1'b1, "R10", "WE in reset", dram_we_n, 1);
    chk(dram_dq_oe == 1'b0, "R10", "driver in reset", dram_dq_oe, 0);
    chk(rsp_valid == 1'b0, "R10", "response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    repeat (30) @(negedge clk);

    // R7 closed-row read latency
    do_req(1'b0, 11'd5, 11'd9, 16'h0);
    drain();
    chk(last_lat == T_RAC + 2, "R7", "closed-row read latency", last_lat, T_RAC + 2);

    // R6 open-row read latency, no RAS activity
    rf = ras_falls; rs = ref_seen;
    repeat (20) @(negedge clk);
    do_req(1'b0, 11'd5, 11'd100, 16'h0);
    drain();
    chk(last_lat == T_CAC + 2, "R6", "open-row read latency", last_lat, T_CAC + 2);

    // R5 back-to-back page hits
    for (int i = 0; i < 6; i++) do_req(1'b1, 11'd5, 11'(i * 3), 16'h1000 + 16'(i));
    chk(last_cas_gap == T_PC, "R5", "back-to-back CAS spacing", last_cas_gap, T_PC);
    for (int i = 0; i < 6; i++) do_req(1'b0, 11'd5, 11'(i * 3), 16'h0);
    drain();
    chk(last_cas_gap == T_PC, "R5", "back-to-back read CAS spacing", last_cas_gap, T_PC);
    chk((ras_falls - rf) == (ref_seen - rs), "R6", "RAS falls during hits",
        ras_falls - rf, ref_seen - rs);

    // R8 / R1 row misses with same column
    rf = ras_falls; rs = ref_seen;
    do_req(1'b1, 11'd6, 11'd9, 16'hBEEF);
    do_req(1'b0, 11'd5, 11'd9, 16'h0);
    do_req(1'b0, 11'd6, 11'd9, 16'h0);
    drain();
    chk((ras_falls - rf) - (ref_seen - rs) == 3, "R8", "activations for three misses",
        (ras_falls - rf) - (ref_seen - rs), 3);
    // R1 top-corner cell and its neighbours
    do_req(1'b1, 11'd2047, 11'd2047, 16'h7E57);
    do_req(1'b1, 11'd2047, 11'd0, 16'h0A0A);
    do_req(1'b0, 11'd2047, 11'd2047, 16'h0);
    do_req(1'b0, 11'd0, 11'd2047, 16'h0);
    drain();
    chk(last_lat >= T_RAC + 2, "R1", "corner miss latency", last_lat, T_RAC + 2);

    // random traffic across several refresh intervals
    for (int n = 0; n < 500; n++) begin
      r = int'($urandom % 8);
      rw = (r < 5) ? 11'(r) : ((r == 5) ? 11'd2047 : 11'($urandom % 2048));
      cl = 11'($urandom % 2048);
      do_req(1'($urandom % 2), rw, cl, 16'($urandom));
      if (($urandom % 4) == 0) repeat (int'($urandom % 30)) @(negedge clk);
    end
    drain();

    repeat (3000) @(negedge clk);
    chk(ref_seen >= (cyc / REF) - 1, "R9", "refresh count", ref_seen, (cyc / REF) - 1);
    chk(exp_q.size() == 0, "R12", "outstanding reads at end", exp_q.size(), 0);
    if (seed_ret == -1) $display("seed note");
    summary();
    $finish;
  end
endmodule